// File: doc/BRIEF.md
# PCI Target Termination Controller

This block drives the target-side handshake of a PCI slave interface. Once an address decoder claims a transaction, the block asserts the device-select response and paces each data phase with the target-ready line. The back end's ready input controls that pacing. The initiator's frame and initiator-ready lines are watched. All bus signals are internal active-high versions of the active-low pins.

The transaction can end in several ways. The back end can request a termination at any time. It can also ask for a target abort. On its own, the block forces a latency disconnect when too many clocks pass without a data transfer. The block tells apart four endings, each with its own drive pattern and rules: a retry (nothing more moves), a disconnect where the last phase completes at once, a disconnect where target-ready is held until the initiator catches up, and an abort.

Every completed data phase is reported on a one-cycle `xfer_o` strobe, which acts as a valid with no ready. The back end applies back-pressure only by holding `be_rdy_i` low, and it cannot refuse a strobe. Once target-ready is asserted, it stays asserted until the initiator takes the word. The way the last transaction ended is latched into a status code, which holds until the next claim.

Top module: `pci_tgt_term`

## Requirements
- R1: While `rst_n` is low, `devsel_o`, `trdy_o`, `stop_o`, `xfer_o` and `term_vld_o` are low.
- R2: When idle, `claim_i` raises `devsel_o` at the next edge with `trdy_o` low. After that, `trdy_o` follows `be_rdy_i` one edge later. A raised `trdy_o` stays high while `irdy_i` is low.
- R3: `xfer_o` is high in exactly those cycles where `devsel_o`, `trdy_o` and `irdy_i` are all high, which gives one strobe per completed data phase.
- R4: Once `stop_o` is high, it stays high until `frame_i` is sampled low.
- R5: In the first cycle of `stop_o`, if `trdy_o` and `irdy_i` are both high, that phase completes. `trdy_o` then drops, and the status code becomes 3.
- R6: In the first cycle of `stop_o`, if `trdy_o` is high and `irdy_i` is low, `trdy_o` is held until `irdy_i` arrives. The status code becomes 2.
- R7: In the first cycle of `stop_o`, if `trdy_o` is low, no data moves for the rest of the transaction, and `be_rdy_i` is ignored. The status code becomes 1.
- R8: After LAT_CLKS (default 8) consecutive claimed cycles with no transfer, `stop_o` rises at the next edge with no new `trdy_o`. The status code becomes 4. Any transfer restarts the count.
- R9: A request with `term_abort_i` high raises `stop_o` while dropping `devsel_o` and `trdy_o` at the same edge. The status code becomes 5.
- R10: At the first edge where `frame_i` is low and no held `trdy_o` is still waiting for `irdy_i`, all of `devsel_o`, `trdy_o` and `stop_o` go low. In the claimed, non-stopping state this also requires that the final phase transfers.
- R11: The status code and `term_vld_o` hold until the next claim. The claim edge clears them to 0/low. A transaction that ends without `stop_o` leaves them at 0/low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| claim_i | input | 1 | Decoder hit; starts a transaction when idle |
| frame_i | input | 1 | Initiator frame (active high) |
| irdy_i | input | 1 | Initiator ready (active high) |
| be_rdy_i | input | 1 | Back end ready to move a word |
| term_req_i | input | 1 | Back end asks for termination |
| term_abort_i | input | 1 | With term_req_i, selects a target abort |
| devsel_o | output | 1 | Device select response |
| trdy_o | output | 1 | Target ready |
| stop_o | output | 1 | Target stop request |
| xfer_o | output | 1 | One-cycle strobe per completed data phase |
| term_vld_o | output | 1 | Status code holds a termination |
| term_type_o | output | 3 | 0 none, 1 retry, 2 held disconnect, 3 immediate disconnect, 4 latency, 5 abort |

## Verification
The bench aims at the first stop cycle, because that one cycle decides between codes 1, 2 and 3. If the classification were taken a cycle late, a held disconnect would be reported as immediate, or as a retry. The latency limit is tested on both sides. A transfer on the eighth idle cycle must prevent any stop. Eight idle cycles with no transfer must raise stop on the very next edge, and an off-by-one counter fails one of these two cases. The bench also checks that a held target-ready survives several cycles of stop, that a ready back end cannot revive target-ready after a retry, and that an abort drops device select at the same edge.

// File: rtl/tt_pkg.sv
package tt_pkg;

  // Status codes reported on term_type_o
  typedef enum logic [2:0] {
    TERM_NONE    = 3'd0,
    TERM_RETRY   = 3'd1,
    TERM_HELD    = 3'd2,
    TERM_IMMED   = 3'd3,
    TERM_LATENCY = 3'd4,
    TERM_ABORT   = 3'd5
  } term_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_STOP,
    ST_ABORT
  } bus_st_e;

  // Target-side bus drive bundle
  typedef struct packed {
    logic devsel;
    logic trdy;
    logic stop;
  } bus_drv_t;

endpackage

// File: rtl/tt_lat_timer.sv
module tt_lat_timer #(
  parameter int LAT_CLKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic active_i,
  input  logic xfer_i,
  output logic expire_o
);
  localparam int CW = $clog2(LAT_CLKS) + 1;
  localparam logic [CW-1:0] LAST = CW'(LAT_CLKS - 1);

  logic [CW-1:0] gap_q;

  // Fires on the edge that would end the LAT_CLKS-th idle cycle
  assign expire_o = active_i & ~xfer_i & (gap_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q <= '0;
    end else if (clear_i | xfer_i) begin
      gap_q <= '0;
    end else if (active_i & ~expire_o) begin
      gap_q <= gap_q + 1'b1;
    end
  end
endmodule

// File: rtl/tt_bus_fsm.sv
module tt_bus_fsm
  import tt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     claim_i,
  input  logic     frame_i,
  input  logic     irdy_i,
  input  logic     be_rdy_i,
  input  logic     term_req_i,
  input  logic     term_abort_i,
  input  logic     lat_expire_i,
  output bus_drv_t drv_o,
  output logic     in_data_o,
  output logic     start_o,
  output logic     lat_stop_o
);
  bus_st_e  st_q, st_d;
  bus_drv_t drv_q, drv_d;
  logic     lat_q, lat_d;
  logic     hold, xfer;

  // Target ready raised but the initiator has not taken the word yet
  assign hold = drv_q.trdy & ~irdy_i;
  assign xfer = drv_q.devsel & drv_q.trdy & irdy_i;

  always_comb begin
    st_d  = st_q;
    drv_d = drv_q;
    lat_d = lat_q;
    unique case (st_q)
      ST_IDLE: begin
        drv_d = '0;
        if (claim_i) begin
          st_d         = ST_DATA;
          drv_d.devsel = 1'b1;
          lat_d        = 1'b0;
        end
      end
      ST_DATA: begin
        if (~frame_i & xfer) begin
          st_d  = ST_IDLE;
          drv_d = '0;
        end else if (term_req_i & term_abort_i) begin
          st_d  = ST_ABORT;
          drv_d = '{devsel: 1'b0, trdy: 1'b0, stop: 1'b1};
        end else if (term_req_i) begin
          st_d       = ST_STOP;
          drv_d.stop = 1'b1;
          drv_d.trdy = hold | be_rdy_i;
        end else if (lat_expire_i) begin
          st_d       = ST_STOP;
          drv_d.stop = 1'b1;
          drv_d.trdy = hold;
          lat_d      = 1'b1;
        end else begin
          drv_d.trdy = hold | be_rdy_i;
        end
      end
      ST_STOP: begin
        if (~frame_i & ~hold) begin
          st_d  = ST_IDLE;
          drv_d = '0;
        end else begin
          drv_d.trdy = hold;
        end
      end
      ST_ABORT: begin
        if (~frame_i) begin
          st_d  = ST_IDLE;
          drv_d = '0;
        end
      end
      default: begin
        st_d  = ST_IDLE;
        drv_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      drv_q <= '0;
      lat_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      drv_q <= drv_d;
      lat_q <= lat_d;
    end
  end

  assign drv_o      = drv_q;
  assign in_data_o  = (st_q == ST_DATA);
  assign start_o    = (st_q == ST_IDLE) & claim_i;
  assign lat_stop_o = lat_q;
endmodule

// File: rtl/tt_term_status.sv
module tt_term_status
  import tt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_i,
  input  bus_drv_t drv_i,
  input  logic     irdy_i,
  input  logic     lat_i,
  output logic     vld_o,
  output term_e    type_o
);
  logic  stop_d;
  logic  first_stop;
  logic  vld_q;
  term_e type_q;

  assign first_stop = drv_i.stop & ~stop_d;

  function automatic term_e classify(input bus_drv_t d, input logic irdy, input logic lat);
    if (lat)                classify = TERM_LATENCY;
    else if (!d.devsel)     classify = TERM_ABORT;
    else if (d.trdy & irdy) classify = TERM_IMMED;
    else if (d.trdy)        classify = TERM_HELD;
    else                    classify = TERM_RETRY;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_d <= 1'b0;
      vld_q  <= 1'b0;
      type_q <= TERM_NONE;
    end else begin
      stop_d <= drv_i.stop;
      if (start_i) begin
        vld_q  <= 1'b0;
        type_q <= TERM_NONE;
      end else if (first_stop) begin
        vld_q  <= 1'b1;
        type_q <= classify(drv_i, irdy_i, lat_i);
      end
    end
  end

  assign vld_o  = vld_q;
  assign type_o = type_q;
endmodule

// File: rtl/pci_tgt_term.sv
module pci_tgt_term
  import tt_pkg::*;
#(
  parameter int LAT_CLKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       claim_i,
  input  logic       frame_i,
  input  logic       irdy_i,
  input  logic       be_rdy_i,
  input  logic       term_req_i,
  input  logic       term_abort_i,
  output logic       devsel_o,
  output logic       trdy_o,
  output logic       stop_o,
  output logic       xfer_o,
  output logic       term_vld_o,
  output logic [2:0] term_type_o
);
  bus_drv_t drv;
  logic     in_data, start, lat_stop, lat_expire, xfer;
  term_e    type_w;

  assign xfer = drv.devsel & drv.trdy & irdy_i;

  tt_lat_timer #(.LAT_CLKS(LAT_CLKS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (start),
    .active_i (in_data),
    .xfer_i   (xfer),
    .expire_o (lat_expire)
  );

  tt_bus_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .claim_i      (claim_i),
    .frame_i      (frame_i),
    .irdy_i       (irdy_i),
    .be_rdy_i     (be_rdy_i),
    .term_req_i   (term_req_i),
    .term_abort_i (term_abort_i),
    .lat_expire_i (lat_expire),
    .drv_o        (drv),
    .in_data_o    (in_data),
    .start_o      (start),
    .lat_stop_o   (lat_stop)
  );

  tt_term_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .drv_i   (drv),
    .irdy_i  (irdy_i),
    .lat_i   (lat_stop),
    .vld_o   (term_vld_o),
    .type_o  (type_w)
  );

  assign devsel_o    = drv.devsel;
  assign trdy_o      = drv.trdy;
  assign stop_o      = drv.stop;
  assign xfer_o      = xfer;
  assign term_type_o = type_w;
endmodule

// File: rtl/tt_checker.sv
module tt_checker #(
  parameter int LAT_CLKS = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       claim_i,
  input logic       frame_i,
  input logic       irdy_i,
  input logic       devsel_o,
  input logic       trdy_o,
  input logic       stop_o,
  input logic       xfer_o,
  input logic       term_vld_o,
  input logic [2:0] term_type_o
);
  localparam int CW = $clog2(LAT_CLKS + 1) + 1;
  logic [CW-1:0] idle_run;

  // Independent count of claimed cycles without a transfer
  always_ff @(posedge clk) begin
    if (!rst_n) idle_run <= '0;
    else if (devsel_o & ~stop_o & ~xfer_o) begin
      if (idle_run < CW'(LAT_CLKS)) idle_run <= idle_run + 1'b1;
    end else idle_run <= '0;
  end

  p_trdy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    devsel_o && trdy_o && !irdy_i |=> trdy_o || !devsel_o);

  p_stop_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o && frame_i |=> stop_o);

  p_retry_nodata_r7: assert property (@(posedge clk) disable iff (!rst_n)
    term_vld_o && term_type_o == 3'd1 && stop_o |-> !trdy_o);

  p_latency_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    devsel_o && !stop_o |-> idle_run < CW'(LAT_CLKS));

  p_abort_shape_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o && !devsel_o |-> !trdy_o);

  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o && !frame_i && (!trdy_o || irdy_i) |=> !stop_o && !devsel_o && !trdy_o);

  p_status_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    claim_i && !devsel_o && !stop_o |=> !term_vld_o);
endmodule

bind pci_tgt_term tt_checker #(.LAT_CLKS(LAT_CLKS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .claim_i     (claim_i),
  .frame_i     (frame_i),
  .irdy_i      (irdy_i),
  .devsel_o    (devsel_o),
  .trdy_o      (trdy_o),
  .stop_o      (stop_o),
  .xfer_o      (xfer_o),
  .term_vld_o  (term_vld_o),
  .term_type_o (term_type_o)
);

// File: tb/sim_pci_tgt_term.sv
module sim_pci_tgt_term;
  logic clk = 1'b0;
  logic rst_n, claim, frame, irdy, be_rdy, treq, tabort;
  logic devsel, trdy, stop, xfer, tvld;
  logic [2:0] ttype;

  int nchk = 0;
  int nerr = 0;

  typedef struct {
    logic [2:0] code;
    logic       vld;
    int         nx;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  pci_tgt_term u0 (
    .clk(clk), .rst_n(rst_n), .claim_i(claim), .frame_i(frame), .irdy_i(irdy),
    .be_rdy_i(be_rdy), .term_req_i(treq), .term_abort_i(tabort),
    .devsel_o(devsel), .trdy_o(trdy), .stop_o(stop), .xfer_o(xfer),
    .term_vld_o(tvld), .term_type_o(ttype)
  );

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_txn(input logic [2:0] code, input logic vld, input int nx);
    exp_t e;
    e.code = code; e.vld = vld; e.nx = nx;
    sb.push_back(e);
  endtask

  task automatic begin_txn(input logic rdy, input logic ir);
    frame = 1; claim = 1; be_rdy = rdy; irdy = ir;
    tick();
    claim = 0;
  endtask

  task automatic to_idle();
    frame = 0; irdy = 0; be_rdy = 0; treq = 0; tabort = 0;
    tick();
  endtask

  task automatic released(input string tag);
    check({tag, " devsel"}, devsel, 0);
    check({tag, " trdy"}, trdy, 0);
    check({tag, " stop"}, stop, 0);
  endtask

  // Monitor: counts strobes per transaction and scores its ending
  int   mon_nx = 0;
  logic prev_busy = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if ((devsel | stop) & xfer) mon_nx++;
      if (prev_busy & ~(devsel | stop)) begin
        if (sb.size() == 0) check("R3 scoreboard underrun", 1, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          check("R3 strobes per transaction", mon_nx, e.nx);
          check("R11 status code at end", ttype, e.code);
          check("R11 status valid at end", tvld, e.vld);
        end
        mon_nx = 0;
      end
      prev_busy = devsel | stop;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst_n = 0; claim = 0; frame = 0; irdy = 0; be_rdy = 0; treq = 0; tabort = 0;
    repeat (3) tick();
    check("R1 devsel in reset", devsel, 0);
    check("R1 trdy in reset", trdy, 0);
    check("R1 stop in reset", stop, 0);
    check("R1 xfer in reset", xfer, 0);
    check("R1 status valid in reset", tvld, 0);
    rst_n = 1;
    tick();

    // Plain burst of three phases
    expect_txn(3'd0, 1'b0, 3);
    begin_txn(1, 1);
    check("R2 devsel after claim", devsel, 1);
    check("R2 trdy low on claim edge", trdy, 0);
    tick();
    check("R2 trdy follows ready", trdy, 1);
    check("R3 strobe with both ready", xfer, 1);
    tick(); tick();
    frame = 0;
    tick();
    released("R10 normal end");
    check("R11 no status after clean end", tvld, 0);
    to_idle();

    // Transfer lands on the last allowed idle cycle: no stop
    expect_txn(3'd0, 1'b0, 1);
    begin_txn(0, 1);
    for (int i = 0; i < 6; i++) tick();
    be_rdy = 1;
    tick();
    check("R8 no stop before limit", stop, 0);
    check("R8 strobe on boundary", xfer, 1);
    frame = 0;
    tick();
    released("R10 boundary end");
    to_idle();

    // Latency disconnect
    expect_txn(3'd4, 1'b1, 0);
    begin_txn(0, 1);
    for (int i = 0; i < 7; i++) tick();
    check("R8 stop low after seven idle edges", stop, 0);
    tick();
    check("R8 stop after limit", stop, 1);
    check("R8 no new trdy on latency stop", trdy, 0);
    check("R8 devsel kept on latency stop", devsel, 1);
    tick();
    check("R8 latency code", ttype, 4);
    frame = 0;
    tick();
    released("R10 latency end");
    to_idle();

    // Disconnect with immediate final phase
    expect_txn(3'd3, 1'b1, 2);
    begin_txn(1, 1);
    tick();
    treq = 1;
    tick();
    treq = 0;
    check("R5 stop raised", stop, 1);
    check("R5 trdy with stop", trdy, 1);
    check("R5 final phase strobe", xfer, 1);
    tick();
    check("R5 trdy dropped after final phase", trdy, 0);
    check("R4 stop kept while frame high", stop, 1);
    check("R5 immediate code", ttype, 3);
    frame = 0;
    tick();
    released("R10 immediate end");
    to_idle();

    // Disconnect with trdy held for a late initiator
    expect_txn(3'd2, 1'b1, 1);
    begin_txn(1, 0);
    tick();
    check("R3 no strobe without irdy", xfer, 0);
    treq = 1;
    tick();
    treq = 0;
    check("R6 stop raised", stop, 1);
    check("R6 trdy with stop", trdy, 1);
    tick();
    check("R6 trdy held", trdy, 1);
    check("R6 held code", ttype, 2);
    tick();
    check("R2 trdy still held", trdy, 1);
    check("R4 stop still high", stop, 1);
    irdy = 1; frame = 0;
    #0;
    check("R6 final strobe on irdy", xfer, 1);
    tick();
    released("R10 held end");
    to_idle();

    // Retry
    expect_txn(3'd1, 1'b1, 0);
    begin_txn(0, 1);
    tick();
    treq = 1;
    tick();
    treq = 0;
    check("R7 stop raised", stop, 1);
    check("R7 trdy low", trdy, 0);
    check("R7 devsel kept", devsel, 1);
    be_rdy = 1;
    tick();
    check("R7 ready ignored after retry", trdy, 0);
    check("R7 retry code", ttype, 1);
    tick();
    check("R4 stop held on retry", stop, 1);
    check("R7 no strobe on retry", xfer, 0);
    frame = 0;
    tick();
    released("R10 retry end");
    to_idle();

    // Target abort
    expect_txn(3'd5, 1'b1, 0);
    begin_txn(1, 0);
    tick();
    treq = 1; tabort = 1;
    tick();
    treq = 0; tabort = 0;
    check("R9 stop on abort", stop, 1);
    check("R9 devsel dropped", devsel, 0);
    check("R9 trdy dropped", trdy, 0);
    tick();
    check("R9 abort code", ttype, 5);
    check("R4 stop held on abort", stop, 1);
    frame = 0;
    tick();
    released("R10 abort end");
    to_idle();

    // Status holds while idle, then a claim clears it
    tick(); tick();
    check("R11 code held while idle", ttype, 5);
    check("R11 valid held while idle", tvld, 1);
    expect_txn(3'd0, 1'b0, 1);
    begin_txn(1, 1);
    check("R11 claim clears valid", tvld, 0);
    check("R11 claim clears code", ttype, 0);
    frame = 0;
    tick();
    check("R3 single strobe", xfer, 1);
    tick();
    released("R10 single end");
    to_idle();

    tick();
    check("R3 scoreboard drained", sb.size(), 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule